// File: doc/BRIEF.md
# Configuration-Space Port Decoder

This block sits on a small I/O port bus and implements the two-window scheme that software uses to reach device configuration headers. One 4-port window holds a 32-bit selector register that software writes and can read back. A second 4-port window is the data window. An access to the data window goes to the header dword named by the selector, on the device the selector names. Accesses may be 1, 2 or 4 bytes wide. The low two bits of the port number pick the starting byte. The block shifts read data down to bit 0, and it shifts write data and byte enables up to the addressed lanes.

The block holds no header contents. Valid data-window accesses leave through a dword port with byte enables to an external per-device register file, which answers reads in the same cycle. Each accepted request produces one registered response carrying read data and an accept flag. The request side is valid/ready. A request is taken only on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is low while an earlier response is waiting for `rsp_ready`. A response stays unchanged until `rsp_ready` takes it. The forwarding port and the device-present flags are plain control pins.

Top module: `cfg_port_decoder`

## Requirements
- R1: A write to the selector window replaces only the addressed byte lanes of the 32-bit selector and leaves the other bytes unchanged. A read of the selector window returns the selector through the same lane extraction as a data read.
- R2: The selector window is ports 0xCF8..0xCFB and the data window is ports 0xCFC..0xCFF. In both windows, port bits 1:0 give the byte offset.
- R3: `req_size` selects the access width: 0 is 1 byte (mask 0xFF), 1 is 2 bytes (mask 0xFFFF), and 2 or 3 is 4 bytes. A claimed read returns (dword >> 8*offset) & mask.
- R4: A selected data-window access drives `cfg_req` in the handshake cycle. `cfg_wdata` is the write data shifted left by 8*offset. `cfg_be` is the width's lane bits shifted left by offset, and lanes above byte 3 are dropped.
- R5: The selector fields are: bit 31 enable, bits 23:16 bus, bits 15:11 device, bits 10:8 function, and bits 7:2 dword index. A data access is selected only when enable is 1, bus is 0, function is 0, the dword index is below 16 (a 64-byte header), and the device's `dev_present` bit is 1.
- R6: A read of any port outside both windows, and a data-window read with nothing selected, returns 0xFFFFFFFF.
- R7: `rsp_ok` is 0 only for a data-window write with nothing selected. Such a write raises no `cfg_req`. Every other access returns `rsp_ok`=1.
- R8: `rsp_valid` rises in the cycle after the handshake. While `rsp_ready` is low, `rsp_valid`, `rsp_rdata` and `rsp_ok` hold and `req_ready` is low.
- R9: After reset, `rsp_valid` is 0 and the selector reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 16 | I/O port number |
| req_size | input | 2 | Access width code |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data, right-aligned |
| rsp_ok | output | 1 | Access accepted |
| dev_present | input | 32 | One flag per device number |
| cfg_req | output | 1 | Register-file access strobe |
| cfg_we | output | 1 | Register-file write |
| cfg_dev | output | 5 | Device number |
| cfg_dword | output | 4 | Header dword index |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rdata | input | 32 | Register-file read data, same cycle |

## Verification
The forwarding outputs are combinational in the handshake cycle. The bench samples `cfg_be` and `cfg_wdata` one time unit after it drives a request and before the clock edge. The selector and the response register both update on the handshake edge. Each response is therefore checked at the falling edge that follows, and the next request sees the new selector. For the back-pressure case, the bench holds `rsp_ready` low for two more cycles and checks at each falling edge that the response stays unchanged and `req_ready` stays low.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef struct packed {
    logic       en;
    logic [6:0] rsvd;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] func;
    logic [5:0] dword;
    logic [1:0] mbz;
  } cfg_sel_t;

  function automatic logic [3:0] lanes_of(input logic [1:0] size);
    case (size)
      2'd0:    lanes_of = 4'b0001;
      2'd1:    lanes_of = 4'b0011;
      default: lanes_of = 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] bits_of(input logic [3:0] lanes);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{lanes[i]}};
    return m;
  endfunction

endpackage

// File: rtl/cfgp_lane_align.sv
module cfgp_lane_align
  import cfgp_pkg::*;
(
  input  logic [1:0]  off,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  output logic [3:0]  be,
  output logic [31:0] wdata_sh
);
  logic [3:0]  base_lanes;
  logic [31:0] base_bits;
  logic [4:0]  shamt;

  always_comb begin
    base_lanes = lanes_of(size);
    base_bits  = bits_of(base_lanes);
    shamt      = {off, 3'b000};
    be         = base_lanes << off;
    wdata_sh   = (wdata & base_bits) << shamt;
  end
endmodule

// File: rtl/cfgp_read_lane.sv
module cfgp_read_lane
  import cfgp_pkg::*;
(
  input  logic [31:0] dword,
  input  logic [1:0]  off,
  input  logic [1:0]  size,
  output logic [31:0] rdata
);
  logic [4:0] shamt;
  always_comb begin
    shamt = {off, 3'b000};
    rdata = (dword >> shamt) & bits_of(lanes_of(size));
  end
endmodule

// File: rtl/cfgp_sel_reg.sv
module cfgp_sel_reg
  import cfgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata_sh,
  output cfg_sel_t    sel_q
);
  logic [31:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < 4; i++)
        if (be[i]) q[i*8 +: 8] <= wdata_sh[i*8 +: 8];
    end
  end

  assign sel_q = cfg_sel_t'(q);

  AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q)); // R1
endmodule

// File: rtl/cfgp_target_decode.sv
module cfgp_target_decode
  import cfgp_pkg::*;
#(
  parameter int DEV_W     = 5,
  parameter int HDR_BYTES = 64,
  localparam int NDEV     = 1 << DEV_W,
  localparam int HDR_DW   = HDR_BYTES / 4,
  localparam int DW_W     = $clog2(HDR_DW)
)(
  input  cfg_sel_t         sel,
  input  logic [NDEV-1:0]  dev_present,
  output logic             hit,
  output logic [DEV_W-1:0] dev,
  output logic [DW_W-1:0]  dword
);
  logic unused_fields;
  logic fields_ok;

  always_comb begin
    dev       = sel.dev[DEV_W-1:0];
    dword     = sel.dword[DW_W-1:0];
    fields_ok = sel.en && (sel.bus == 8'd0) && (sel.func == 3'd0) &&
                (int'(sel.dword) < HDR_DW);
    hit       = fields_ok && dev_present[dev];
  end

  assign unused_fields = ^{sel.rsvd, sel.mbz};
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfgp_pkg::*;
#(
  parameter int          DEV_W     = 5,
  parameter int          HDR_BYTES = 64,
  parameter logic [15:0] SEL_BASE  = 16'hCF8,
  parameter logic [15:0] DATA_BASE = 16'hCFC,
  localparam int         NDEV      = 1 << DEV_W,
  localparam int         DW_W      = $clog2(HDR_BYTES / 4)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [15:0]      req_port,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_rdata,
  output logic             rsp_ok,
  input  logic [NDEV-1:0]  dev_present,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic [DEV_W-1:0] cfg_dev,
  output logic [DW_W-1:0]  cfg_dword,
  output logic [3:0]       cfg_be,
  output logic [31:0]      cfg_wdata,
  input  logic [31:0]      cfg_rdata
);
  logic        fire, in_sel_win, in_data_win, hit;
  logic [1:0]  off;
  logic [3:0]  be;
  logic [31:0] wdata_sh, sel_word, src_word, lane_out, rd_next;
  cfg_sel_t    sel_q;

  assign req_ready   = !rsp_valid || rsp_ready;
  assign fire        = req_valid && req_ready;
  assign off         = req_port[1:0];
  assign in_sel_win  = req_port[15:2] == SEL_BASE[15:2];
  assign in_data_win = req_port[15:2] == DATA_BASE[15:2];

  cfgp_lane_align u_align (
    .off(off), .size(req_size), .wdata(req_wdata),
    .be(be), .wdata_sh(wdata_sh)
  );

  cfgp_sel_reg u_sel (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fire && req_write && in_sel_win),
    .be(be), .wdata_sh(wdata_sh), .sel_q(sel_q)
  );

  cfgp_target_decode #(.DEV_W(DEV_W), .HDR_BYTES(HDR_BYTES)) u_dec (
    .sel(sel_q), .dev_present(dev_present),
    .hit(hit), .dev(cfg_dev), .dword(cfg_dword)
  );

  assign sel_word = sel_q;
  assign src_word = in_sel_win ? sel_word : cfg_rdata;

  cfgp_read_lane u_rd (
    .dword(src_word), .off(off), .size(req_size), .rdata(lane_out)
  );

  assign cfg_req   = fire && in_data_win && hit;
  assign cfg_we    = req_write;
  assign cfg_be    = be;
  assign cfg_wdata = wdata_sh;

  always_comb begin
    if (in_sel_win || (in_data_win && hit)) rd_next = lane_out;
    else                                    rd_next = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_ok    <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_next;
      rsp_ok    <= !(req_write && in_data_win && !hit);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_ok)); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R8
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R8
  AST_READ_OK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_ok); // R7
  AST_CFG_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> req_valid && req_ready && (cfg_be != 4'b0000)); // R4
endmodule

// File: tb/tb_cfg_port_decoder.sv
module tb_cfg_port_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [15:0] req_port = 0;
  logic [1:0]  req_size = 0;
  logic [31:0] req_wdata = 0;
  logic        req_ready, rsp_valid, rsp_ok, cfg_req, cfg_we;
  logic [31:0] rsp_rdata, cfg_wdata, cfg_rdata;
  logic [31:0] dev_present = 32'hA5F3_7E1D;
  logic [4:0]  cfg_dev;
  logic [3:0]  cfg_dword, cfg_be;

  logic [31:0] mem    [32][16];
  logic [31:0] shadow [32][16];
  logic [31:0] m_sel;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_decoder dut (.*);

  assign cfg_rdata = mem[cfg_dev][cfg_dword];
  always @(posedge clk)
    if (cfg_req && cfg_we)
      for (int i = 0; i < 4; i++)
        if (cfg_be[i]) mem[cfg_dev][cfg_dword][i*8 +: 8] <= cfg_wdata[i*8 +: 8];

  function automatic logic [31:0] msk(input logic [1:0] s);
    return s == 0 ? 32'hFF : s == 1 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] wd,
                                        input logic [1:0] off, input logic [1:0] s);
    logic [31:0] m = msk(s) << (8*off);
    return (old & ~m) | ((wd & msk(s)) << (8*off));
  endfunction
  function automatic logic [31:0] extract(input logic [31:0] v, input logic [1:0] off,
                                          input logic [1:0] s);
    return (v >> (8*off)) & msk(s);
  endfunction
  function automatic bit m_hit();
    return m_sel[31] && m_sel[23:16] == 0 && m_sel[10:8] == 0 &&
           m_sel[7:2] < 16 && dev_present[m_sel[15:11]];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input string req, input bit wr, input logic [15:0] port,
                        input logic [1:0] s, input logic [31:0] wd);
    logic [31:0] exp_d; logic exp_ok; bit h;
    h = m_hit();
    @(negedge clk);
    req_valid = 1; req_write = wr; req_port = port; req_size = s; req_wdata = wd;
    exp_ok = 1; exp_d = wr ? 32'h0 : 32'hFFFF_FFFF;
    if (port[15:2] == 14'h33E) begin
      if (wr) m_sel = merge(m_sel, wd, port[1:0], s);
      else exp_d = extract(m_sel, port[1:0], s);
    end else if (port[15:2] == 14'h33F) begin
      if (!h && wr) exp_ok = 0;
      if (h && !wr) exp_d = extract(shadow[m_sel[15:11]][m_sel[5:2]], port[1:0], s);
      if (h && wr) shadow[m_sel[15:11]][m_sel[5:2]] =
        merge(shadow[m_sel[15:11]][m_sel[5:2]], wd, port[1:0], s);
    end
    @(negedge clk);
    req_valid = 0;
    check({req, " rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
    check({req, " rdata"}, rsp_rdata, exp_d);
    check({req, " ok"}, {31'b0, rsp_ok}, {31'b0, exp_ok});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    for (int d = 0; d < 32; d++)
      for (int w = 0; w < 16; w++) begin
        mem[d][w] = $urandom; shadow[d][w] = mem[d][w];
      end
    m_sel = 0;
    repeat (3) @(negedge clk);
    check("R9 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1;
    access("R9 selector reset", 0, 16'hCF8, 2, 0);

    // R1 byte-lane merge and readback
    access("R1 full write", 1, 16'hCF8, 2, 32'h8000_1808);
    access("R1 byte write", 1, 16'hCFA, 0, 32'h0000_00EE);
    access("R1 readback hi half", 0, 16'hCFA, 1, 0);
    access("R1 byte3 read", 0, 16'hCFB, 0, 0);
    access("R1 restore bus", 1, 16'hCFA, 0, 32'h0);

    // R3/R5 selected reads of various widths (dev 3 present)
    access("R3 word read", 0, 16'hCFC, 2, 0);
    access("R3 byte read off2", 0, 16'hCFE, 0, 0);
    access("R3 half read off1", 0, 16'hCFD, 1, 0);

    // R4 forwarding lanes checked at handshake cycle
    @(negedge clk);
    req_valid = 1; req_write = 1; req_port = 16'hCFD; req_size = 1; req_wdata = 32'h1234_ABCD;
    #1;
    check("R4 cfg_req", {31'b0, cfg_req}, 32'd1);
    check("R4 cfg_be", {28'b0, cfg_be}, 32'h6);
    check("R4 cfg_wdata[23:8]", cfg_wdata & 32'h00FF_FF00, 32'h00AB_CD00);
    shadow[3][2] = merge(shadow[3][2], 32'h1234_ABCD, 2'd1, 2'd1);
    @(negedge clk); req_valid = 0;
    access("R4 write then read", 0, 16'hCFC, 2, 0);
    access("R4 offset3 wide write", 1, 16'hCFF, 2, 32'hCAFE_F00D);
    access("R4 offset3 readback", 0, 16'hCFC, 2, 0);

    // R5 rejection cases, R6 all ones, R7 reject flag
    access("R5 disable", 1, 16'hCF8, 2, 32'h0000_1808);
    access("R6 disabled read", 0, 16'hCFC, 2, 0);
    access("R7 disabled write", 1, 16'hCFC, 2, 32'h1);
    access("R5 bus1", 1, 16'hCF8, 2, 32'h8001_1808);
    access("R6 bus1 read", 0, 16'hCFC, 2, 0);
    access("R5 func1", 1, 16'hCF8, 2, 32'h8000_1908);
    access("R7 func1 write", 1, 16'hCFC, 2, 32'h1);
    access("R5 offset16", 1, 16'hCF8, 2, 32'h8000_1840);
    access("R6 offset16 read", 0, 16'hCFD, 0, 0);
    access("R5 offset15", 1, 16'hCF8, 2, 32'h8000_183C);
    access("R5 offset15 read", 0, 16'hCFC, 2, 0);
    access("R5 absent dev1", 1, 16'hCF8, 2, 32'h8000_0800);
    access("R7 absent write", 1, 16'hCFC, 2, 32'h5);
    access("R6 absent read", 0, 16'hCFC, 0, 0);
    access("R2 other port read", 0, 16'h0CF7, 2, 0);
    access("R2 other port write", 1, 16'h0D00, 2, 32'h7);
    access("R2 other port 0x1CF8", 0, 16'h1CF8, 2, 0);

    // R8 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_port = 16'hCF8; req_size = 2;
    @(negedge clk);
    req_valid = 0;
    check("R8 valid", {31'b0, rsp_valid}, 32'd1);
    check("R8 data", rsp_rdata, m_sel);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check("R8 hold valid", {31'b0, rsp_valid}, 32'd1);
      check("R8 hold data", rsp_rdata, m_sel);
      check("R8 ready low", {31'b0, req_ready}, 32'd0);
    end
    rsp_ready = 1;
    @(negedge clk);
    check("R8 drained", {31'b0, rsp_valid}, 32'd0);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int r = $urandom % 10;
      logic [1:0] s = 2'($urandom % 4);
      if (r < 2) begin
        logic [31:0] v;
        v = {($urandom % 8) != 0, 7'd0, 8'(($urandom % 6) == 0),
             5'($urandom), 3'(($urandom % 6) == 0), 6'($urandom % 20), 2'b00};
        if (r == 0) access("R1 rand sel write", 1, 16'hCF8, 2, v);
        else access("R1 rand sel lane", 1, 16'hCF8 + 16'($urandom % 4), s, $urandom);
      end else if (r == 2) access("R1 rand sel read", 0, 16'hCF8 + 16'($urandom % 4), s, 0);
      else if (r < 6) access("R3 rand data read", 0, 16'hCFC + 16'($urandom % 4), s, 0);
      else if (r < 9) access("R4 rand data write", 1, 16'hCFC + 16'($urandom % 4), s, $urandom);
      else access("R6 rand other", $urandom % 2, 16'($urandom) | 16'h4000, s, $urandom);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule